// File: doc/BRIEF.md
# Interrupt Controller Register Decoder

This block is the memory-mapped register front end for an interrupt controller core. It accepts 32-bit word reads and writes from a simple valid/ready request channel. It works out which register region the byte offset falls in, and then issues a single access on the core's configuration port. The regions are per-source priority, packed pending bits, per-context enable words, and per-context threshold and claim/complete registers. Read data returns on a valid/ready response channel.

The claim/complete register has a side effect that depends on the direction of the access. A read is a claim, and the core returns the claimed source ID. A write is a complete, and it carries the source ID to release. Every accepted request passes through a three-state machine. `IDLE` accepts a request. `ISSUE` drives the configuration port for exactly one cycle and captures the read data. `RESP` holds the response until the bus takes it. The transitions are `IDLE->ISSUE` on a request handshake, `ISSUE->RESP` unconditionally, and `RESP->IDLE` on a response handshake. The core is never touched twice for one request, so a stalled response cannot cause a second claim.

Accesses that are not word aligned are dropped silently. Writes to pending words, offsets past the valid enable words, unused context offsets and addresses outside every region are dropped, read as zero and report an error with the response.

Top module: `intc_reg_decoder`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0 and `cfg_valid` is 0.
- R2: A request whose address has either of bits [1:0] set makes no configuration access. It responds with data 0 and `rsp_err` 0.
- R3: An offset `4*k` into the priority region is an access of kind 0 (priority) with `cfg_index` = k+1, for k below the source count. A read returns the core's `cfg_rdata` unchanged.
- R4: An offset `4*w` into the pending region is a read of kind 1 (pending) with `cfg_index` = w. A write anywhere in that region makes no configuration access and responds with `rsp_err` 1.
- R5: In the enable region the context is the offset divided by the enable stride, and the word is the offset bits below the stride divided by 4. The access has kind 2. A word index at or above the bitfield word count makes no access and responds with `rsp_err` 1 and data 0.
- R6: In the context region, offset 0 within a stride is the threshold (kind 3). Offset 4 within a stride is kind 4: a read is a claim, and a write is a complete whose `cfg_wdata` is the written ID. Any other offset within a stride makes no access, reads 0 and responds with `rsp_err` 1.
- R7: An address outside all four regions makes no access, reads 0 and responds with `rsp_err` 1.
- R8: Each accepted request raises `cfg_valid` for at most one cycle, whatever the response stall. That cycle is followed by the response.
- R9: `rsp_valid`, `rsp_rdata` and `rsp_err` hold steady until `rsp_ready` is high. `req_ready` is low from acceptance until the response completes.
- R10: The bitfield word count is (sources + 31) / 32. With 40 sources, pending word 1 and enable word 1 are valid, and pending word 2 and enable word 2 are errors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset into the register aperture |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken when high with rsp_valid |
| rsp_rdata | output | DATA_W | Read data, 0 for writes and dropped accesses |
| rsp_err | output | 1 | Access was rejected as an error |
| cfg_valid | output | 1 | One-cycle configuration access strobe |
| cfg_write | output | 1 | Configuration access direction |
| cfg_kind | output | 3 | 0 priority, 1 pending, 2 enable, 3 threshold, 4 claim/complete |
| cfg_index | output | IDX_W | Source number or bitfield word index |
| cfg_ctx | output | CTX_W | Context number |
| cfg_wdata | output | DATA_W | Write data passed to the core |
| cfg_rdata | input | DATA_W | Core read data, valid in the cfg_valid cycle |

## Verification
Two functions can fall in the same cycle. One is a claim whose response is still held back by a low `rsp_ready`. The other is the arrival of the next request on the request channel. The bench keeps a claim response stalled for several cycles and presents a second request during that stall. It then checks that `req_ready` stays low, that the claim count seen on the configuration port does not change, and that the held response data stays the same. After the stall is released, the bench checks that exactly one claim was issued for that handshake.

// File: rtl/intc_reg_pkg.sv
package intc_reg_pkg;

    typedef enum logic [2:0] {
        K_PRIO   = 3'd0,
        K_PEND   = 3'd1,
        K_ENABLE = 3'd2,
        K_THRESH = 3'd3,
        K_CLAIM  = 3'd4
    } cfg_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_RESP  = 2'd2
    } ctrl_state_e;

endpackage

// File: rtl/intc_reg_region.sv
module intc_reg_region
    import intc_reg_pkg::*;
#(
    parameter int unsigned ADDR_W     = 24,
    parameter int unsigned N_SRC      = 40,
    parameter int unsigned N_CTX      = 3,
    parameter int unsigned PRIO_BASE  = 32'h0000,
    parameter int unsigned PEND_BASE  = 32'h1000,
    parameter int unsigned EN_BASE    = 32'h2000,
    parameter int unsigned EN_STRIDE  = 32'h80,
    parameter int unsigned CTX_BASE   = 32'h20_0000,
    parameter int unsigned CTX_STRIDE = 32'h1000,
    parameter int unsigned IDX_W      = 6,
    parameter int unsigned CTX_W      = 2
) (
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic              err,
    output cfg_kind_e         kind,
    output logic [IDX_W-1:0]  index,
    output logic [CTX_W-1:0]  ctx
);
    localparam int unsigned WORDS  = (N_SRC + 31) / 32;
    localparam int unsigned EN_SH  = $clog2(EN_STRIDE);
    localparam int unsigned CTX_SH = $clog2(CTX_STRIDE);

    localparam logic [ADDR_W-1:0] P_SIZE = ADDR_W'(N_SRC * 4);
    localparam logic [ADDR_W-1:0] N_SIZE = ADDR_W'(WORDS * 4);
    localparam logic [ADDR_W-1:0] E_SIZE = ADDR_W'(N_CTX * EN_STRIDE);
    localparam logic [ADDR_W-1:0] C_SIZE = ADDR_W'(N_CTX * CTX_STRIDE);
    localparam logic [ADDR_W-1:0] E_MASK = ADDR_W'(EN_STRIDE - 1);
    localparam logic [ADDR_W-1:0] C_MASK = ADDR_W'(CTX_STRIDE - 1);
    localparam logic [ADDR_W-1:0] N_WRDS = ADDR_W'(WORDS);

    logic [ADDR_W-1:0] p_off, n_off, e_off, c_off, e_word, c_sub;
    logic              aligned;

    assign aligned = (addr[1:0] == 2'b00);
    assign p_off   = addr - ADDR_W'(PRIO_BASE);
    assign n_off   = addr - ADDR_W'(PEND_BASE);
    assign e_off   = addr - ADDR_W'(EN_BASE);
    assign c_off   = addr - ADDR_W'(CTX_BASE);
    assign e_word  = (e_off & E_MASK) >> 2;
    assign c_sub   = c_off & C_MASK;

    always_comb begin
        hit   = 1'b0;
        err   = 1'b0;
        kind  = K_PRIO;
        index = '0;
        ctx   = '0;
        if (!aligned) begin
            hit = 1'b0;
        end else if (p_off < P_SIZE) begin
            hit   = 1'b1;
            kind  = K_PRIO;
            index = IDX_W'(p_off >> 2) + IDX_W'(1);
        end else if (n_off < N_SIZE) begin
            if (write) begin
                err = 1'b1;
            end else begin
                hit   = 1'b1;
                kind  = K_PEND;
                index = IDX_W'(n_off >> 2);
            end
        end else if (e_off < E_SIZE) begin
            if (e_word < N_WRDS) begin
                hit   = 1'b1;
                kind  = K_ENABLE;
                index = IDX_W'(e_word);
                ctx   = CTX_W'(e_off >> EN_SH);
            end else begin
                err = 1'b1;
            end
        end else if (c_off < C_SIZE) begin
            ctx = CTX_W'(c_off >> CTX_SH);
            if (c_sub == ADDR_W'(0)) begin
                hit  = 1'b1;
                kind = K_THRESH;
            end else if (c_sub == ADDR_W'(4)) begin
                hit  = 1'b1;
                kind = K_CLAIM;
            end else begin
                err = 1'b1;
            end
        end else begin
            err = 1'b1;
        end
    end
endmodule

// File: rtl/intc_reg_ctrl.sv
module intc_reg_ctrl
    import intc_reg_pkg::*;
#(
    parameter int unsigned ADDR_W = 24,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err,
    output logic              lat_write,
    output logic [ADDR_W-1:0] lat_addr,
    output logic [DATA_W-1:0] lat_wdata,
    input  logic              dec_hit,
    input  logic              dec_err,
    output logic              cfg_valid,
    input  logic [DATA_W-1:0] cfg_rdata
);
    ctrl_state_e state, state_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (req_valid) state_nx = ST_ISSUE;
            ST_ISSUE: state_nx = ST_RESP;
            ST_RESP:  if (rsp_ready) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        cfg_valid = 1'b0;
        unique case (state)
            ST_IDLE:  req_ready = 1'b1;
            ST_ISSUE: cfg_valid = dec_hit;
            ST_RESP:  rsp_valid = 1'b1;
            default:  req_ready = 1'b0;
        endcase
    end

    // request latch and response capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_write <= 1'b0;
            lat_addr  <= '0;
            lat_wdata <= '0;
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
        end else begin
            if (state == ST_IDLE && req_valid) begin
                lat_write <= req_write;
                lat_addr  <= req_addr;
                lat_wdata <= req_wdata;
            end
            if (state == ST_ISSUE) begin
                rsp_rdata <= (dec_hit && !lat_write) ? cfg_rdata : '0;
                rsp_err   <= dec_err;
            end
        end
    end
endmodule

// File: rtl/intc_reg_decoder.sv
module intc_reg_decoder
    import intc_reg_pkg::*;
#(
    parameter int unsigned ADDR_W     = 24,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned N_SRC      = 40,
    parameter int unsigned N_CTX      = 3,
    parameter int unsigned PRIO_BASE  = 32'h0000,
    parameter int unsigned PEND_BASE  = 32'h1000,
    parameter int unsigned EN_BASE    = 32'h2000,
    parameter int unsigned EN_STRIDE  = 32'h80,
    parameter int unsigned CTX_BASE   = 32'h20_0000,
    parameter int unsigned CTX_STRIDE = 32'h1000,
    parameter int unsigned IDX_W      = $clog2(N_SRC + 1),
    parameter int unsigned CTX_W      = (N_CTX > 1) ? $clog2(N_CTX) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err,
    output logic              cfg_valid,
    output logic              cfg_write,
    output logic [2:0]        cfg_kind,
    output logic [IDX_W-1:0]  cfg_index,
    output logic [CTX_W-1:0]  cfg_ctx,
    output logic [DATA_W-1:0] cfg_wdata,
    input  logic [DATA_W-1:0] cfg_rdata
);
    logic              lat_write;
    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] lat_wdata;
    logic              dec_hit, dec_err;
    cfg_kind_e         dec_kind;

    intc_reg_region #(
        .ADDR_W(ADDR_W), .N_SRC(N_SRC), .N_CTX(N_CTX),
        .PRIO_BASE(PRIO_BASE), .PEND_BASE(PEND_BASE),
        .EN_BASE(EN_BASE), .EN_STRIDE(EN_STRIDE),
        .CTX_BASE(CTX_BASE), .CTX_STRIDE(CTX_STRIDE),
        .IDX_W(IDX_W), .CTX_W(CTX_W)
    ) u_region (
        .write (lat_write),
        .addr  (lat_addr),
        .hit   (dec_hit),
        .err   (dec_err),
        .kind  (dec_kind),
        .index (cfg_index),
        .ctx   (cfg_ctx)
    );

    intc_reg_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_ready (rsp_ready),
        .rsp_rdata (rsp_rdata),
        .rsp_err   (rsp_err),
        .lat_write (lat_write),
        .lat_addr  (lat_addr),
        .lat_wdata (lat_wdata),
        .dec_hit   (dec_hit),
        .dec_err   (dec_err),
        .cfg_valid (cfg_valid),
        .cfg_rdata (cfg_rdata)
    );

    assign cfg_write = lat_write;
    assign cfg_wdata = lat_wdata;
    assign cfg_kind  = dec_kind;
endmodule

// File: rtl/intc_reg_checker.sv
module intc_reg_checker #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned N_SRC  = 40,
    parameter int unsigned IDX_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              rsp_err,
    input logic              cfg_valid,
    input logic              cfg_write,
    input logic [2:0]        cfg_kind,
    input logic [IDX_W-1:0]  cfg_index
);
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |=> !cfg_valid);                                         // R8
    AST_STROBE_THEN_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |=> rsp_valid);                                          // R8
    AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err))); // R9
    AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);                                         // R9
    AST_ACCEPT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);                          // R9
    AST_PEND_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && cfg_kind == 3'd1) |-> !cfg_write);                   // R4
    AST_PRIO_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && cfg_kind == 3'd0) |-> (cfg_index >= IDX_W'(1) && cfg_index <= IDX_W'(N_SRC))); // R3
    AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> (cfg_kind <= 3'd4));                                 // R6
endmodule

bind intc_reg_decoder intc_reg_checker #(
    .DATA_W(DATA_W), .N_SRC(N_SRC), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .cfg_valid(cfg_valid), .cfg_write(cfg_write),
    .cfg_kind(cfg_kind), .cfg_index(cfg_index)
);

// File: tb/tb_intc_reg_decoder.sv
module tb_intc_reg_decoder;
    localparam int ADDR_W = 24;
    localparam int DATA_W = 32;
    localparam int IDX_W  = 6;
    localparam int CTX_W  = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              req_ready, rsp_valid, rsp_err;
    logic [DATA_W-1:0] rsp_rdata;
    logic              cfg_valid, cfg_write;
    logic [2:0]        cfg_kind;
    logic [IDX_W-1:0]  cfg_index;
    logic [CTX_W-1:0]  cfg_ctx;
    logic [DATA_W-1:0] cfg_wdata, cfg_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // core model data: kind in [22:20], ctx in [13:12], index in [5:0]
    function automatic logic [DATA_W-1:0] core_val(input int k, input int c, input int i);
        return 32'hA000_0000 | (k << 20) | (c << 12) | i;
    endfunction
    assign cfg_rdata = core_val(int'(cfg_kind), int'(cfg_ctx), int'(cfg_index));

    always #10 clk = ~clk;

    intc_reg_decoder dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
        .rsp_err(rsp_err), .cfg_valid(cfg_valid), .cfg_write(cfg_write),
        .cfg_kind(cfg_kind), .cfg_index(cfg_index), .cfg_ctx(cfg_ctx),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
    );

    // configuration port monitor, sampled mid-cycle
    int          n_cfg = 0;
    int          m_kind, m_idx, m_ctx;
    logic        m_write;
    logic [31:0] m_wdata;
    always @(negedge clk) begin
        if (cfg_valid) begin
            n_cfg++;
            m_kind  = int'(cfg_kind);
            m_idx   = int'(cfg_index);
            m_ctx   = int'(cfg_ctx);
            m_write = cfg_write;
            m_wdata = cfg_wdata;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    logic [31:0] r_data;
    logic        r_err;
    int          r_ncfg;
    bit          r_stable;

    task automatic access(input bit w, input logic [ADDR_W-1:0] a,
                          input logic [31:0] d, input int stall);
        int base = n_cfg;
        logic [31:0] held;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        rsp_ready = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid) @(negedge clk);
        held = rsp_rdata;
        r_stable = 1'b1;
        for (int i = 0; i < stall; i++) begin
            @(negedge clk);
            if (!rsp_valid || rsp_rdata != held) r_stable = 1'b0;
        end
        r_data = rsp_rdata; r_err = rsp_err;
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        r_ncfg = n_cfg - base;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
        chk(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
        chk(cfg_valid == 1'b0, "R1 cfg_valid", cfg_valid, 0);
    endtask

    task automatic t_misaligned();
        access(1'b0, 24'h000002, 0, 0);
        chk(r_ncfg == 0, "R2 no access", r_ncfg, 0);
        chk(r_data == 0 && r_err == 0, "R2 data/err", {r_err, r_data}, 0);
        access(1'b1, 24'h201005, 32'h5, 0);
        chk(r_ncfg == 0 && r_err == 0, "R2 write dropped", r_ncfg, 0);
    endtask

    task automatic t_priority();
        access(1'b0, 24'h000000, 0, 0);
        chk(r_ncfg == 1 && m_kind == 0 && m_idx == 1, "R3 first slot idx", m_idx, 1);
        chk(r_data == core_val(0, 0, 1), "R3 read data", r_data, core_val(0, 0, 1));
        access(1'b1, 24'h00009C, 32'h6, 0);
        chk(m_idx == 40 && m_write && m_wdata == 32'h6 && !r_err, "R3 last slot write", m_idx, 40);
    endtask

    task automatic t_pending();
        access(1'b0, 24'h001004, 0, 0);
        chk(r_ncfg == 1 && m_kind == 1 && m_idx == 1, "R4 R10 pending word1", m_idx, 1);
        chk(r_data == core_val(1, 0, 1), "R4 pending data", r_data, core_val(1, 0, 1));
        access(1'b1, 24'h001000, 32'hFFFF_FFFF, 0);
        chk(r_ncfg == 0 && r_err == 1, "R4 pending write rejected", {r_ncfg, r_err}, 1);
        access(1'b0, 24'h001008, 0, 0);
        chk(r_ncfg == 0 && r_err == 1 && r_data == 0, "R10 pending word2", {r_ncfg, r_err}, 1);
    endtask

    task automatic t_enable();
        access(1'b1, 24'h002104, 32'h1234, 0);
        chk(r_ncfg == 1 && m_kind == 2 && m_ctx == 2 && m_idx == 1 && m_wdata == 32'h1234,
            "R5 R10 ctx2 word1", {m_ctx, m_idx}, 33);
        access(1'b0, 24'h002088, 0, 0);
        chk(r_ncfg == 0 && r_err == 1 && r_data == 0, "R5 R10 word2 invalid", {r_ncfg, r_err}, 1);
        access(1'b0, 24'h002080, 0, 0);
        chk(r_data == core_val(2, 1, 0), "R5 ctx1 word0 read", r_data, core_val(2, 1, 0));
    endtask

    task automatic t_context();
        access(1'b1, 24'h202000, 32'h3, 0);
        chk(r_ncfg == 1 && m_kind == 3 && m_ctx == 2 && m_wdata == 3, "R6 threshold", m_kind, 3);
        access(1'b1, 24'h201004, 32'h7, 0);
        chk(r_ncfg == 1 && m_kind == 4 && m_write && m_wdata == 7 && m_ctx == 1, "R6 complete", m_wdata, 7);
        access(1'b0, 24'h201008, 0, 0);
        chk(r_ncfg == 0 && r_err == 1 && r_data == 0, "R6 unused offset", {r_ncfg, r_err}, 1);
    endtask

    task automatic t_unmapped();
        access(1'b0, 24'h0000A0, 0, 0);
        chk(r_ncfg == 0 && r_err == 1 && r_data == 0, "R7 past priority", {r_ncfg, r_err}, 1);
        access(1'b1, 24'h002180, 32'h1, 0);
        chk(r_ncfg == 0 && r_err == 1, "R7 past enable", {r_ncfg, r_err}, 1);
    endtask

    task automatic t_claim_stall();
        int base;
        bit blocked = 1'b1;
        logic [31:0] held;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        base = n_cfg;
        req_valid = 1'b1; req_write = 1'b0; req_addr = 24'h200004;
        @(negedge clk);
        req_addr = 24'h201004;
        while (!rsp_valid) @(negedge clk);
        held = rsp_rdata;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (req_ready || rsp_rdata != held || n_cfg - base != 1) blocked = 1'b0;
        end
        req_valid = 1'b0;
        chk(blocked, "R8 R9 stalled claim blocks new request", blocked, 1);
        chk(held == core_val(4, 0, 0), "R6 claim data", held, core_val(4, 0, 0));
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk(n_cfg - base == 1 && m_kind == 4 && !m_write, "R8 single claim", n_cfg - base, 1);
        access(1'b0, 24'h200004, 0, 4);
        chk(r_stable && r_ncfg == 1, "R9 held response", {r_stable, r_ncfg}, 3);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_misaligned();
        t_priority();
        t_pending();
        t_enable();
        t_context();
        t_unmapped();
        t_claim_stall();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R9 watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule